// File: doc/BRIEF.md
# Instruction Cycle Phase Controller

This block is the hardwired sequencer that steps a simple processor through three kinds of machine cycle: fetching an instruction, executing it, and entering an interrupt. The current kind of cycle is held in two flag bits, F (high bit) and E (low bit). A small step counter times the micro-operations inside a cycle. The decoded counter value drives one-hot control strobes toward the datapath.

The fetch sequence is fixed. At its end the block rewrites its own flags to enter execute. During execute, an external execute sequencer does the work and signals completion. The block then picks between a new fetch and an interrupt cycle. The interrupt cycle saves context, loads the handler address into PC, acknowledges the request, and returns to fetch.

All strobes, the flags and the step count come from registers. Each result appears on the clock edge that samples the inputs causing it.

Top module: `cycle_phase_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the flags at {F,E}=00 (idle), the step count at 0 and every strobe low. Idle holds while start_i is low, whatever exec_done_i, irq_i and mem_rdy_i do.
- R2: start_i high while idle moves the flags to 10 (fetch) with step 0 on the next edge. start_i has no effect in any other cycle.
- R3: In fetch step 0, mar_ld_o (PC into MAR) is the only strobe high, and the step advances to 1 on the next edge.
- R4: In fetch step 1, mem_rd_o is high on every cycle. The step holds at 1 until mem_rdy_i is sampled high. pc_inc_o is high exactly once per fetch, on the first cycle of step 1, together with mem_rd_o.
- R5: Fetch step 2 raises ir_ld_o (MDR into IR). Fetch step 3 raises fetch_end_o. The next edge sets the flags to 01 (execute) with step 0.
- R6: step_o shows the step count, and it returns to 0 on every change of cycle. At most one of mar_ld_o, mem_rd_o, ir_ld_o, fetch_end_o, ctx_save_o, vec_ld_o, int_ack_o, exec_go_o is high in any cycle.
- R7: In execute, exec_go_o is high and step_o is 0. When exec_done_i is sampled high, the next edge goes to 11 (interrupt) if irq_i and irq_en_i are both high, and to 10 (fetch) otherwise.
- R8: The interrupt cycle raises ctx_save_o at step 0, vec_ld_o at step 1 and int_ack_o at step 2, one cycle each. The next edge after that returns to 10 (fetch) with step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Leave idle and begin fetching |
| irq_i | input | 1 | Interrupt request |
| irq_en_i | input | 1 | Interrupt enable |
| exec_done_i | input | 1 | Execute sequencer finished |
| mem_rdy_i | input | 1 | Memory read data is available |
| flag_f_o | output | 1 | Cycle flag F |
| flag_e_o | output | 1 | Cycle flag E |
| step_o | output | STEP_W | Step count within the cycle |
| mar_ld_o | output | 1 | Copy PC into MAR |
| mem_rd_o | output | 1 | Read memory into MDR |
| pc_inc_o | output | 1 | Increment PC |
| ir_ld_o | output | 1 | Copy MDR into IR |
| fetch_end_o | output | 1 | Final fetch step, flags switch to execute |
| exec_go_o | output | 1 | Execute sequencer may run |
| ctx_save_o | output | 1 | Save program context |
| vec_ld_o | output | 1 | Load PC with handler start address |
| int_ack_o | output | 1 | Acknowledge interrupt request |

## Verification
Every result is due one clock after the edge that samples its cause:
- A start pulse, a mem_rdy_i high or an exec_done_i high is seen at one rising edge.
- The new flags, the new step and the matching strobes are already stable after that same edge.

The bench changes inputs on falling edges and advances its model on the rising edge that the design also uses. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Wait states on mem_rdy_i stretch only step 1, and the model counts them without assuming a fixed fetch length.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  // Cycle code: bit 1 is flag F, bit 0 is flag E.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_EXEC  = 2'b01,
    CYC_FETCH = 2'b10,
    CYC_INTR  = 2'b11
  } cyc_e;

  // Number of steps in the fixed micro-sequences.
  localparam int FETCH_STEPS = 4;
  localparam int INTR_STEPS  = 3;

  // Step in which the fetch waits for memory.
  localparam int READ_STEP = 1;

  typedef struct packed {
    logic mar_ld;
    logic mem_rd;
    logic pc_inc;
    logic ir_ld;
    logic fetch_end;
    logic ctx_save;
    logic vec_ld;
    logic int_ack;
    logic exec_go;
  } strobe_t;

endpackage

// File: rtl/cyc_next.sv
module cyc_next
  import cyc_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  cyc_e              cyc_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              start_i,
  input  logic              mem_rdy_i,
  input  logic              exec_done_i,
  input  logic              irq_i,
  input  logic              irq_en_i,
  output cyc_e              cyc_nxt_o,
  output logic [STEP_W-1:0] step_nxt_o
);

  localparam logic [STEP_W-1:0] F_LAST = STEP_W'(FETCH_STEPS - 1);
  localparam logic [STEP_W-1:0] I_LAST = STEP_W'(INTR_STEPS - 1);
  localparam logic [STEP_W-1:0] S_RD   = STEP_W'(READ_STEP);
  localparam logic [STEP_W-1:0] ONE    = STEP_W'(1);

  always_comb begin
    cyc_nxt_o  = cyc_i;
    step_nxt_o = step_i;
    case (cyc_i)
      CYC_IDLE: begin
        if (start_i) begin
          cyc_nxt_o  = CYC_FETCH;
          step_nxt_o = '0;
        end
      end
      CYC_FETCH: begin
        if (step_i == F_LAST) begin
          cyc_nxt_o  = CYC_EXEC;
          step_nxt_o = '0;
        end else if ((step_i != S_RD) || mem_rdy_i) begin
          step_nxt_o = step_i + ONE;
        end
      end
      CYC_EXEC: begin
        step_nxt_o = '0;
        if (exec_done_i) begin
          cyc_nxt_o = (irq_i && irq_en_i) ? CYC_INTR : CYC_FETCH;
        end
      end
      CYC_INTR: begin
        if (step_i == I_LAST) begin
          cyc_nxt_o  = CYC_FETCH;
          step_nxt_o = '0;
        end else begin
          step_nxt_o = step_i + ONE;
        end
      end
      default: begin
        cyc_nxt_o  = CYC_IDLE;
        step_nxt_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/phase_regs.sv
module phase_regs
  import cyc_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc_nxt_i,
  input  logic [STEP_W-1:0] step_nxt_i,
  output cyc_e              cyc_o,
  output logic [STEP_W-1:0] step_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_o  <= CYC_IDLE;
      step_o <= '0;
    end else begin
      cyc_o  <= cyc_nxt_i;
      step_o <= step_nxt_i;
    end
  end

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import cyc_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc_i,
  input  logic [STEP_W-1:0] step_i,
  input  cyc_e              cyc_nxt_i,
  input  logic [STEP_W-1:0] step_nxt_i,
  output strobe_t           stb_o
);

  localparam int NSTEP = 2 ** STEP_W;
  localparam logic [STEP_W-1:0] S_RD = STEP_W'(READ_STEP);

  // One-hot decode of the step that becomes current at the next edge.
  logic [NSTEP-1:0] hot;
  for (genvar k = 0; k < NSTEP; k++) begin : g_dec
    assign hot[k] = (step_nxt_i == STEP_W'(k));
  end

  logic    in_f, in_i, now_rd;
  strobe_t d;

  always_comb begin
    in_f   = (cyc_nxt_i == CYC_FETCH);
    in_i   = (cyc_nxt_i == CYC_INTR);
    now_rd = (cyc_i == CYC_FETCH) && (step_i == S_RD);

    d           = '0;
    d.mar_ld    = in_f && hot[0];
    d.mem_rd    = in_f && hot[READ_STEP];
    d.pc_inc    = in_f && hot[READ_STEP] && !now_rd;
    d.ir_ld     = in_f && hot[2];
    d.fetch_end = in_f && hot[FETCH_STEPS-1];
    d.ctx_save  = in_i && hot[0];
    d.vec_ld    = in_i && hot[1];
    d.int_ack   = in_i && hot[INTR_STEPS-1];
    d.exec_go   = (cyc_nxt_i == CYC_EXEC);
  end

  always_ff @(posedge clk) begin
    if (rst) stb_o <= '0;
    else     stb_o <= d;
  end

endmodule

// File: rtl/cycle_phase_ctrl.sv
module cycle_phase_ctrl
  import cyc_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              irq_i,
  input  logic              irq_en_i,
  input  logic              exec_done_i,
  input  logic              mem_rdy_i,
  output logic              flag_f_o,
  output logic              flag_e_o,
  output logic [STEP_W-1:0] step_o,
  output logic              mar_ld_o,
  output logic              mem_rd_o,
  output logic              pc_inc_o,
  output logic              ir_ld_o,
  output logic              fetch_end_o,
  output logic              exec_go_o,
  output logic              ctx_save_o,
  output logic              vec_ld_o,
  output logic              int_ack_o
);

  cyc_e              cyc_q, cyc_d;
  logic [STEP_W-1:0] step_q, step_d;
  strobe_t           stb;

  cyc_next #(.STEP_W(STEP_W)) u_next (
    .cyc_i       (cyc_q),
    .step_i      (step_q),
    .start_i     (start_i),
    .mem_rdy_i   (mem_rdy_i),
    .exec_done_i (exec_done_i),
    .irq_i       (irq_i),
    .irq_en_i    (irq_en_i),
    .cyc_nxt_o   (cyc_d),
    .step_nxt_o  (step_d)
  );

  phase_regs #(.STEP_W(STEP_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cyc_nxt_i  (cyc_d),
    .step_nxt_i (step_d),
    .cyc_o      (cyc_q),
    .step_o     (step_q)
  );

  strobe_gen #(.STEP_W(STEP_W)) u_stb (
    .clk        (clk),
    .rst        (rst),
    .cyc_i      (cyc_q),
    .step_i     (step_q),
    .cyc_nxt_i  (cyc_d),
    .step_nxt_i (step_d),
    .stb_o      (stb)
  );

  assign flag_f_o    = cyc_q[1];
  assign flag_e_o    = cyc_q[0];
  assign step_o      = step_q;
  assign mar_ld_o    = stb.mar_ld;
  assign mem_rd_o    = stb.mem_rd;
  assign pc_inc_o    = stb.pc_inc;
  assign ir_ld_o     = stb.ir_ld;
  assign fetch_end_o = stb.fetch_end;
  assign exec_go_o   = stb.exec_go;
  assign ctx_save_o  = stb.ctx_save;
  assign vec_ld_o    = stb.vec_ld;
  assign int_ack_o   = stb.int_ack;

endmodule

// File: rtl/cycle_phase_chk.sv
module cycle_phase_chk #(
  parameter int STEP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              irq_i,
  input logic              irq_en_i,
  input logic              exec_done_i,
  input logic              mem_rdy_i,
  input logic              flag_f_o,
  input logic              flag_e_o,
  input logic [STEP_W-1:0] step_o,
  input logic              mar_ld_o,
  input logic              mem_rd_o,
  input logic              pc_inc_o,
  input logic              ir_ld_o,
  input logic              fetch_end_o,
  input logic              exec_go_o,
  input logic              ctx_save_o,
  input logic              vec_ld_o,
  input logic              int_ack_o
);

  logic [1:0] fe;
  assign fe = {flag_f_o, flag_e_o};

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (fe == 2'b00 && start_i) |=> (fe == 2'b10 && step_o == '0));

  // R3
  mar_then_read_chk: assert property (@(posedge clk) disable iff (rst)
    mar_ld_o |=> (mem_rd_o && pc_inc_o));

  // R4
  mem_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && !pc_inc_o));

  // R5
  fetch_end_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_end_o |=> (fe == 2'b01 && step_o == '0));

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mar_ld_o, mem_rd_o, ir_ld_o, fetch_end_o,
              ctx_save_o, vec_ld_o, int_ack_o, exec_go_o}));

  // R7
  exec_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (fe == 2'b01 && exec_done_i && irq_i && irq_en_i) |=> (fe == 2'b11));

  // R8
  ctx_then_vec_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_save_o |=> vec_ld_o);

endmodule

bind cycle_phase_ctrl cycle_phase_chk #(.STEP_W(STEP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .irq_i       (irq_i),
  .irq_en_i    (irq_en_i),
  .exec_done_i (exec_done_i),
  .mem_rdy_i   (mem_rdy_i),
  .flag_f_o    (flag_f_o),
  .flag_e_o    (flag_e_o),
  .step_o      (step_o),
  .mar_ld_o    (mar_ld_o),
  .mem_rd_o    (mem_rd_o),
  .pc_inc_o    (pc_inc_o),
  .ir_ld_o     (ir_ld_o),
  .fetch_end_o (fetch_end_o),
  .exec_go_o   (exec_go_o),
  .ctx_save_o  (ctx_save_o),
  .vec_ld_o    (vec_ld_o),
  .int_ack_o   (int_ack_o)
);

// File: tb/sim_cycle_phase_ctrl.sv
`timescale 1ns/1ps
module sim_cycle_phase_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, irq_i = 1'b0, irq_en_i = 1'b0;
  logic exec_done_i = 1'b0, mem_rdy_i = 1'b1;
  logic flag_f_o, flag_e_o;
  logic [1:0] step_o;
  logic mar_ld_o, mem_rd_o, pc_inc_o, ir_ld_o, fetch_end_o;
  logic exec_go_o, ctx_save_o, vec_ld_o, int_ack_o;

  always #4 clk = ~clk;

  cycle_phase_ctrl #(.STEP_W(2)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .irq_i(irq_i),
    .irq_en_i(irq_en_i), .exec_done_i(exec_done_i), .mem_rdy_i(mem_rdy_i),
    .flag_f_o(flag_f_o), .flag_e_o(flag_e_o), .step_o(step_o),
    .mar_ld_o(mar_ld_o), .mem_rd_o(mem_rd_o), .pc_inc_o(pc_inc_o),
    .ir_ld_o(ir_ld_o), .fetch_end_o(fetch_end_o), .exec_go_o(exec_go_o),
    .ctx_save_o(ctx_save_o), .vec_ld_o(vec_ld_o), .int_ack_o(int_ack_o)
  );

  int total = 0;
  int bad   = 0;
  int ticks = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: cycle code as integer F*2+E, step as integer.
  int  mc = 0, ms = 0;
  bit  mfirst = 1'b0;

  always @(posedge clk) begin
    bit was_rd;
    was_rd = (mc == 2 && ms == 1);
    if (rst) begin
      mc = 0; ms = 0;
    end else begin
      case (mc)
        0: if (start_i) begin mc = 2; ms = 0; end
        2: begin
          if (ms == 3) begin mc = 1; ms = 0; end
          else if (!(ms == 1 && !mem_rdy_i)) ms = ms + 1;
        end
        1: begin
          ms = 0;
          if (exec_done_i) mc = (irq_i && irq_en_i) ? 3 : 2;
        end
        default: begin
          if (ms == 2) begin mc = 2; ms = 0; end
          else ms = ms + 1;
        end
      endcase
    end
    mfirst = !rst && (mc == 2 && ms == 1) && !was_rd;
  end

  // Compare every output on each falling edge.
  int pc_cnt = 0;
  always @(negedge clk) begin
    if (!done) begin
      chk("R6", "flags", {flag_f_o, flag_e_o}, mc);
      chk("R6", "step", step_o, ms);
      chk("R3", "mar_ld", mar_ld_o, (mc == 2 && ms == 0));
      chk("R4", "mem_rd", mem_rd_o, (mc == 2 && ms == 1));
      chk("R4", "pc_inc", pc_inc_o, mfirst);
      chk("R5", "ir_ld", ir_ld_o, (mc == 2 && ms == 2));
      chk("R5", "fetch_end", fetch_end_o, (mc == 2 && ms == 3));
      chk("R7", "exec_go", exec_go_o, (mc == 1));
      chk("R8", "ctx_save", ctx_save_o, (mc == 3 && ms == 0));
      chk("R8", "vec_ld", vec_ld_o, (mc == 3 && ms == 1));
      chk("R8", "int_ack", int_ack_o, (mc == 3 && ms == 2));
      if (mar_ld_o) pc_cnt = 0;
      if (pc_inc_o) pc_cnt++;
      // R4: a single PC increment per fetch, however long the wait
      if (ir_ld_o) chk("R4", "pc_inc per fetch", pc_cnt, 1);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    chk(tag, "reset flags", {flag_f_o, flag_e_o}, 0);
    chk(tag, "reset step", step_o, 0);
    chk(tag, "reset strobes",
        {mar_ld_o, mem_rd_o, pc_inc_o, ir_ld_o, fetch_end_o,
         exec_go_o, ctx_save_o, vec_ld_o, int_ack_o}, 0);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", ticks, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R1: reset state
    check_reset_state("R1");
    // R1: idle ignores everything but start
    exec_done_i = 1'b1; irq_i = 1'b1; irq_en_i = 1'b1; mem_rdy_i = 1'b0;
    wait_cyc(4);
    chk("R1", "idle hold", {flag_f_o, flag_e_o}, 0);
    exec_done_i = 1'b0; irq_i = 1'b0; irq_en_i = 1'b0; mem_rdy_i = 1'b1;
    // R2: start enters fetch
    start_i = 1'b1;
    wait_cyc(1);
    start_i = 1'b0;
    chk("R2", "start to fetch", {flag_f_o, flag_e_o}, 2);
    chk("R3", "step0 MAR load", mar_ld_o, 1);
    // Fetch without wait, then execute
    wait_cyc(6);
    chk("R7", "in execute", exec_go_o, 1);
    // R2: start ignored during execute
    start_i = 1'b1;
    wait_cyc(1);
    start_i = 1'b0;
    chk("R2", "start ignored", {flag_f_o, flag_e_o}, 1);
    // R7: done without request returns to fetch
    exec_done_i = 1'b1;
    wait_cyc(1);
    exec_done_i = 1'b0;
    chk("R7", "done to fetch", {flag_f_o, flag_e_o}, 2);
    // R4: memory wait of several cycles
    mem_rdy_i = 1'b0;
    wait_cyc(6);
    chk("R4", "held in read step", step_o, 1);
    mem_rdy_i = 1'b1;
    wait_cyc(5);
    // R7: request masked by enable
    irq_i = 1'b1; irq_en_i = 1'b0; exec_done_i = 1'b1;
    wait_cyc(1);
    exec_done_i = 1'b0;
    chk("R7", "masked request", {flag_f_o, flag_e_o}, 2);
    wait_cyc(5);
    // R7, R8: enabled request enters interrupt cycle
    irq_en_i = 1'b1; exec_done_i = 1'b1;
    wait_cyc(1);
    exec_done_i = 1'b0;
    chk("R7", "enabled request", {flag_f_o, flag_e_o}, 3);
    chk("R8", "context save", ctx_save_o, 1);
    wait_cyc(3);
    chk("R8", "back to fetch", {flag_f_o, flag_e_o}, 2);
    irq_i = 1'b0; irq_en_i = 1'b0;
    // Mixed input patterns, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      start_i     = ($urandom % 8) == 0;
      mem_rdy_i   = ($urandom % 3) != 0;
      exec_done_i = ($urandom % 4) == 0;
      irq_i       = ($urandom % 2) == 0;
      irq_en_i    = ($urandom % 2) == 0;
      wait_cyc(1);
    end
    // R1: reset in the middle of a run
    rst = 1'b1;
    wait_cyc(1);
    rst = 1'b0;
    start_i = 1'b0;
    check_reset_state("R1");
    wait_cyc(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule